// File: doc/BRIEF.md
# Three-Wire Converter Serial Port

This block is the slave side of a three-wire host link for a dual-slope converter. It has one shared serial clock, one data line in each direction, and a direction select. The host drives the direction select high to read. In that mode the port sends a status-plus-result frame. The first bit of the frame is the live end-of-conversion level, so the host can poll for new data by watching the output line alone. The remaining bits are taken from a copy of the converter's holding register, made at the moment reading began.

The host drives the direction select low to write. In that mode the port collects an eight-bit timing value. When the direction select returns high, the port commits that value to the conversion timebase and issues a one-cycle start strobe. A write counts only if it began while the end-of-conversion line was low, which is the auto-zero window. A write begun at any other time is flagged and discarded. A write that carries fewer than eight bits leaves the stored value unchanged.

All three host lines are sampled in the system clock domain through two-flop synchronisers. Serial clock edges and direction edges are detected from the synchronised levels.

Top module: `adc_sport`

## Requirements
- R1: While reset is asserted, and directly after it is released with the direction input low, `load_val` is 0 and `conv_start`, `wr_err` and `ser_dout_en` are all 0.
- R2: `ser_dout_en` is 1 only while the synchronised direction input is high (read mode). While `ser_dout_en` is 0, `ser_dout` is 0, even when the serial clock toggles and `eoc_n` is 1.
- R3: After the direction input rises, and before the first falling serial clock edge of the frame, `ser_dout` equals the current `eoc_n` input and follows it combinationally.
- R4: Each falling serial clock edge in read mode advances the frame. After fall k, where k runs from 1 to DW+2, `ser_dout` shows bit k of the sequence overrange, polarity, data[DW-1] down to data[0]. After the frame is used up, `ser_dout` is 0.
- R5: The frame bits are copied from `res_ovr`, `res_pol` and `res_data` when the direction input rises. Changes on those inputs during the read do not alter the frame.
- R6: In write mode, `ser_din` is sampled on each rising serial clock edge, MSB first. When the direction input rises after at least 8 bits were sampled, `load_val` takes the last 8 bits sampled. In the same cycle `conv_start` is 1, and it is 1 for exactly one cycle.
- R7: If fewer than 8 bits were sampled before the direction input rises, `load_val` keeps its previous value and `conv_start` stays 0.
- R8: If the direction input falls while `eoc_n` is 1, `wr_err` is 1 for exactly one cycle. The commit that ends that write leaves `load_val` unchanged and issues no `conv_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Host serial clock, asynchronous to clk |
| ser_din | input | 1 | Host write data |
| rd_wr_n | input | 1 | Direction select: 1 read, 0 write |
| ser_dout | output | 1 | Read data to host |
| ser_dout_en | output | 1 | Output driver enable for ser_dout |
| eoc_n | input | 1 | Live end-of-conversion level, low during auto-zero |
| res_ovr | input | 1 | Overrange bit of the holding register |
| res_pol | input | 1 | Polarity bit of the holding register |
| res_data | input | DW | Conversion magnitude of the holding register |
| load_val | output | LW | Committed timebase load value |
| conv_start | output | 1 | One-cycle conversion start strobe |
| wr_err | output | 1 | One-cycle flag for a write begun outside auto-zero |

## Verification
Two situations are the hardest to reach from the ports. The first is proving that the frame is a snapshot: the stimulus changes every result input after a few frame bits have already gone out, then checks that the remaining bits still match the old word. The second is the live end-of-conversion bit, which is observed only in the short window between the direction rise and the first falling clock. The bench toggles `eoc_n` inside that window and checks `ser_dout` each time. Rejected writes are checked against short bit counts, against a write begun while end-of-conversion is high, and against over-long writes, where only the last eight bits count.

// File: rtl/adc_sport_pkg.sv
package adc_sport_pkg;
  // positions of the host lines inside the synchroniser vector
  localparam int unsigned IX_SCK = 0;
  localparam int unsigned IX_DIN = 1;
  localparam int unsigned IX_RW  = 2;
  localparam int unsigned N_LINES = 3;
  // lines that need edge detection: serial clock and direction
  localparam int unsigned N_EDGE = 2;
  localparam int unsigned EX_SCK = 0;
  localparam int unsigned EX_RW  = 1;
endpackage

// File: rtl/adc_sport_sync.sv
module adc_sport_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/adc_sport_edge.sv
module adc_sport_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_q <= '0;
    else        prv_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] = lvl[i] & ~prv_q[i];
    assign fall[i] = ~lvl[i] & prv_q[i];
  end
endmodule

// File: rtl/adc_sport_rdsh.sv
module adc_sport_rdsh #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rw_lvl,
  input  logic          rw_rise,
  input  logic          sck_fall,
  input  logic          eoc_n,
  input  logic          res_ovr,
  input  logic          res_pol,
  input  logic [DW-1:0] res_data,
  output logic          sdo,
  output logic          sdo_en
);
  localparam int unsigned FW   = DW + 2;
  localparam int unsigned CW   = $clog2(FW + 2);
  localparam logic [CW-1:0] CMAX = CW'(FW + 1);

  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (!rw_lvl) begin
      cnt_d = '0;
    end else if (rw_rise) begin
      sh_d  = {res_ovr, res_pol, res_data};
      cnt_d = '0;
    end else if (sck_fall) begin
      if (cnt_q == '0) begin
        cnt_d = CW'(1);
      end else begin
        sh_d = {sh_q[FW-2:0], 1'b0};
        if (cnt_q != CMAX) cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // bit zero of the frame is the live end-of-conversion level
  assign sdo_en = rw_lvl;
  assign sdo    = rw_lvl & ((cnt_q == '0) ? eoc_n : sh_q[FW-1]);
endmodule

// File: rtl/adc_sport_wrcap.sv
module adc_sport_wrcap #(
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rw_lvl,
  input  logic          rw_rise,
  input  logic          rw_fall,
  input  logic          sck_rise,
  input  logic          din_lvl,
  input  logic          eoc_n,
  output logic [LW-1:0] load_val,
  output logic          start,
  output logic          err
);
  localparam int unsigned BW = $clog2(LW + 1);
  localparam logic [BW-1:0] FULL = BW'(LW);

  logic [LW-1:0] in_q, in_d, ld_q, ld_d;
  logic [BW-1:0] bc_q, bc_d;
  logic          ok_q, ok_d, st_q, st_d, er_q, er_d;

  always_comb begin
    in_d = in_q;
    ld_d = ld_q;
    bc_d = bc_q;
    ok_d = ok_q;
    st_d = 1'b0;
    er_d = 1'b0;
    if (rw_fall) begin
      bc_d = '0;
      ok_d = ~eoc_n;
      er_d = eoc_n;
    end else if (!rw_lvl && sck_rise) begin
      in_d = {in_q[LW-2:0], din_lvl};
      if (bc_q != FULL) bc_d = bc_q + BW'(1);
    end else if (rw_rise) begin
      if (ok_q && (bc_q == FULL)) begin
        ld_d = in_q;
        st_d = 1'b1;
      end
      ok_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= '0;
      ld_q <= '0;
      bc_q <= '0;
      ok_q <= 1'b0;
      st_q <= 1'b0;
      er_q <= 1'b0;
    end else begin
      in_q <= in_d;
      ld_q <= ld_d;
      bc_q <= bc_d;
      ok_q <= ok_d;
      st_q <= st_d;
      er_q <= er_d;
    end
  end

  assign load_val = ld_q;
  assign start    = st_q;
  assign err      = er_q;
endmodule

// File: rtl/adc_sport.sv
module adc_sport
  import adc_sport_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_din,
  input  logic          rd_wr_n,
  output logic          ser_dout,
  output logic          ser_dout_en,
  input  logic          eoc_n,
  input  logic          res_ovr,
  input  logic          res_pol,
  input  logic [DW-1:0] res_data,
  output logic [LW-1:0] load_val,
  output logic          conv_start,
  output logic          wr_err
);
  logic [N_LINES-1:0] raw, lvl;
  logic [N_EDGE-1:0]  elvl, rise, fall;

  assign raw[IX_SCK] = ser_clk;
  assign raw[IX_DIN] = ser_din;
  assign raw[IX_RW]  = rd_wr_n;

  adc_sport_sync #(.N(N_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(lvl)
  );

  assign elvl[EX_SCK] = lvl[IX_SCK];
  assign elvl[EX_RW]  = lvl[IX_RW];

  adc_sport_edge #(.N(N_EDGE)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(elvl), .rise(rise), .fall(fall)
  );

  adc_sport_rdsh #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rw_lvl(lvl[IX_RW]), .rw_rise(rise[EX_RW]), .sck_fall(fall[EX_SCK]),
    .eoc_n(eoc_n), .res_ovr(res_ovr), .res_pol(res_pol), .res_data(res_data),
    .sdo(ser_dout), .sdo_en(ser_dout_en)
  );

  adc_sport_wrcap #(.LW(LW)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .rw_lvl(lvl[IX_RW]), .rw_rise(rise[EX_RW]), .rw_fall(fall[EX_RW]),
    .sck_rise(rise[EX_SCK]), .din_lvl(lvl[IX_DIN]), .eoc_n(eoc_n),
    .load_val(load_val), .start(conv_start), .err(wr_err)
  );
endmodule

// File: rtl/adc_sport_chk.sv
module adc_sport_chk #(
  parameter int unsigned LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_dout,
  input logic          ser_dout_en,
  input logic [LW-1:0] load_val,
  input logic          conv_start,
  input logic          wr_err
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!conv_start && !wr_err && !ser_dout_en && load_val == '0);
    end
  end

  // R2
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_dout_en |-> !ser_dout);

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R7
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(load_val) |-> conv_start);

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> !wr_err);

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_err && conv_start));
endmodule

bind adc_sport adc_sport_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
  .load_val(load_val), .conv_start(conv_start), .wr_err(wr_err)
);

// File: tb/adc_sport_test.sv
module adc_sport_test;
  localparam int DW = 16;
  localparam int LW = 8;
  localparam int FW = DW + 2;
  localparam int ST = 6;

  logic clk, rst_n, ser_clk, ser_din, rd_wr_n, eoc_n, res_ovr, res_pol;
  logic [DW-1:0] res_data;
  logic ser_dout, ser_dout_en, conv_start, wr_err;
  logic [LW-1:0] load_val;

  int n_chk = 0, n_fail = 0, n_start = 0, n_err = 0;

  adc_sport #(.DW(DW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .rd_wr_n(rd_wr_n), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
    .eoc_n(eoc_n), .res_ovr(res_ovr), .res_pol(res_pol), .res_data(res_data),
    .load_val(load_val), .conv_start(conv_start), .wr_err(wr_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (conv_start) n_start++;
    if (wr_err) n_err++;
  end

  // read vectors: [18] eoc_n, [17] overrange, [16] polarity, [15:0] data
  localparam logic [18:0] RV [4] = '{
    19'h0_A5C3, 19'h7_FFFF, 19'h2_0001, 19'h5_8000
  };

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic open_read(input logic e, input logic [FW-1:0] fr);
    eoc_n = e; res_ovr = fr[FW-1]; res_pol = fr[FW-2]; res_data = fr[DW-1:0];
    rd_wr_n = 1'b0; cyc(ST);
    rd_wr_n = 1'b1; cyc(ST);
  endtask

  task automatic fall_rise(output logic seen);
    ser_clk = 1'b0; cyc(ST);
    seen = ser_dout;
    ser_clk = 1'b1; cyc(ST);
  endtask

  task automatic do_write(input logic e, input logic [15:0] v, input int nb);
    eoc_n = e; rd_wr_n = 1'b0; cyc(ST);
    for (int i = nb - 1; i >= 0; i--) begin
      ser_clk = 1'b0; ser_din = v[i]; cyc(ST);
      ser_clk = 1'b1; cyc(ST);
    end
    rd_wr_n = 1'b1; cyc(ST);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic b;
    logic [FW-1:0] fr;
    int s0, e0;
    rst_n = 1'b0; ser_clk = 1'b1; ser_din = 1'b0; rd_wr_n = 1'b0;
    eoc_n = 1'b1; res_ovr = 1'b0; res_pol = 1'b0; res_data = '0;
    cyc(4);
    chk("R1 load in reset", load_val, 0);
    chk("R1 dout_en in reset", ser_dout_en, 0);
    rst_n = 1'b1; cyc(ST);
    chk("R1 load after reset", load_val, 0);
    chk("R1 start/err after reset", {conv_start, wr_err, ser_dout_en}, 0);

    // table walk: full read frames
    foreach (RV[k]) begin
      fr = RV[k][FW-1:0];
      open_read(RV[k][18], fr);
      chk("R3 first bit is eoc", ser_dout, RV[k][18]);
      chk("R2 enabled in read", ser_dout_en, 1);
      for (int i = FW - 1; i >= 0; i--) begin
        fall_rise(b);
        chk("R4 frame bit", b, fr[i]);
      end
      fall_rise(b);
      chk("R4 past frame end", b, 0);
    end

    // R3: live eoc before first fall
    open_read(1'b0, 18'h1_2345);
    eoc_n = 1'b1; #1;
    chk("R3 live eoc high", ser_dout, 1);
    eoc_n = 1'b0; #1;
    chk("R3 live eoc low", ser_dout, 0);

    // R5: snapshot holds while inputs change mid-frame
    fr = 18'h2_9C6A;
    open_read(1'b0, fr);
    for (int i = FW - 1; i >= 0; i--) begin
      if (i == FW - 4) begin
        res_ovr = ~fr[FW-1]; res_pol = ~fr[FW-2]; res_data = ~fr[DW-1:0];
      end
      fall_rise(b);
      chk("R5 snapshot bit", b, fr[i]);
    end

    // R2: write mode keeps output off
    eoc_n = 1'b1; rd_wr_n = 1'b0; cyc(ST);
    ser_clk = 1'b0; cyc(ST);
    chk("R2 dout_en in write", ser_dout_en, 0);
    chk("R2 dout in write", ser_dout, 0);
    ser_clk = 1'b1; cyc(ST);
    rd_wr_n = 1'b1; cyc(ST);

    // R6: valid 8-bit write
    s0 = n_start; e0 = n_err;
    do_write(1'b0, 16'h00A5, 8);
    chk("R6 load value", load_val, 8'hA5);
    chk("R6 one start pulse", n_start - s0, 1);
    chk("R6 no error", n_err - e0, 0);

    // R7: short write ignored
    s0 = n_start;
    do_write(1'b0, 16'h001F, 5);
    chk("R7 load kept", load_val, 8'hA5);
    chk("R7 no start", n_start - s0, 0);

    // R8: write begun with eoc high
    s0 = n_start; e0 = n_err;
    do_write(1'b1, 16'h003C, 8);
    chk("R8 one error pulse", n_err - e0, 1);
    chk("R8 load kept", load_val, 8'hA5);
    chk("R8 no start", n_start - s0, 0);

    // R6: over-long write keeps last eight bits
    s0 = n_start;
    do_write(1'b0, 16'h02C3, 10);
    chk("R6 last eight bits", load_val, 8'hC3);
    chk("R6 start on long write", n_start - s0, 1);

    finish_run();
  end
endmodule